// File: doc/BRIEF.md
# Load-Based Mode and Phase Controller

This block supervises a six-phase step-down regulator from the digital side. Each time the current-sense logic delivers a fresh average load figure (in 10 mA units, qualified by a one-cycle valid strobe), the controller decides how many phases should switch, whether the regulator runs in PWM or PFM, and whether the deeper low-power PFM state is permitted. The active phases are reported as a count and as a thermometer enable vector that the interleave timing logic consumes.

The PWM/PFM decision uses two separate programmable current levels with a hysteresis band between them. Phase adding and shedding compare the load against a per-phase level multiplied by the present phase count, so the trip points scale as phases come and go. A forced-PWM control overrides the automatic mode choice. A dwell counter spaces phase changes in time, and a configuration check flags threshold settings that leave too little hysteresis.

Top module: `load_mode_ctl`

## Requirements
- R1: After reset the phase count is 1, the mode output is PFM (2'b00) and the phase enable vector is 6'b000001.
- R2: While the converter enable is low the phase count is 1 and the mode is PWM (2'b10) if forced PWM is set, PFM (2'b00) otherwise, from the next clock edge.
- R3: While enabled with forced PWM set, the mode is PWM (2'b10) from the next edge at every load and sleep setting.
- R4: In PFM, an evaluated load strictly above the PFM exit level switches to PWM; exit codes 3..7 map to 175, 225, 275, 325, 375 mA, and codes 0..2 act as code 3 (175 mA).
- R5: In PWM (not forced), an evaluated load strictly below the PFM entry level switches to PFM; entry codes 0..4 map to 100, 125, 150, 175, 225 mA and codes 5..7 act as code 4 (225 mA); loads between the two levels keep the mode.
- R6: In PWM, a phase is added when the load is strictly above (add level × active phases), up to 6 phases; the add level is (code+3)×100 mA for codes 2..7, and codes 0..1 act as code 2 (500 mA).
- R7: In PWM, a phase is shed when the load is strictly below (shed level × active phases), down to 1 phase; the shed level is (code+3)×100 mA for codes 0..5, and codes 6..7 act as code 5 (800 mA). Adding takes priority over shedding.
- R8: The phase count changes by at most one per evaluation and only on a cycle where the load valid strobe is high.
- R9: After a phase change, no further change occurs until the dwell count of clock cycles has elapsed: with dwell D and continuous evaluation, successive changes are D+1 edges apart.
- R10: Phase enable bit i is 1 exactly when i is less than the phase count.
- R11: When the automatic choice moves to PFM the phase count returns to 1 on the same edge.
- R12: In PFM, the mode becomes low-power PFM (2'b01) from the next edge only when both low-power enable inputs are 1 and the sleep input equals the polarity bit (1 = active high, 0 = active low); otherwise it is plain PFM.
- R13: The configuration error output is 1 when the resolved add level is not above the resolved shed level, or when the resolved PFM exit level is less than 150 mA above the resolved entry level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| convEnable | input | 1 | Converter enable; low holds one phase |
| forcePwm | input | 1 | Forces PWM at all loads |
| lowPwrEnable | input | 1 | Global low-power PFM permission |
| lowPwrAllow | input | 1 | Converter low-power PFM permission |
| sleepIn | input | 1 | Sleep request pin |
| sleepPolHigh | input | 1 | Sleep polarity: 1 active high, 0 active low |
| pfmEntryCode | input | 3 | PFM entry level code |
| pfmExitCode | input | 3 | PFM exit level code |
| phaseAddCode | input | 3 | Per-phase add level code |
| phaseShedCode | input | 3 | Per-phase shed level code |
| dwellTicks | input | 8 | Minimum cycles between phase changes |
| loadValid | input | 1 | Strobe: loadCur holds a new measurement |
| loadCur | input | 12 | Average load current, 10 mA per LSB |
| phaseCount | output | 3 | Active phase count, 1 to 6 |
| modeOut | output | 2 | 00 PFM, 01 low-power PFM, 10 PWM |
| phaseEn | output | 6 | Thermometer phase enable vector |
| cfgErr | output | 1 | Threshold configuration error |

## Verification
The hardest situation to reach is the dwell window under back-to-back evaluations: it only shows when the load stays far above every add threshold while valid is held high for many cycles. The bench forces PWM, holds a saturating load with valid asserted continuously, and checks the exact edges at which the count steps, which also exposes any multi-step jump. Reserved threshold codes are exercised by choosing loads one LSB on either side of the clamped level.

// File: rtl/lmc_pkg.sv
package lmc_pkg;

  typedef enum logic [1:0] {
    MODE_PFM  = 2'b00,
    MODE_LPFM = 2'b01,
    MODE_PWM  = 2'b10
  } mode_e;

  // control -> datapath strobes
  typedef struct packed {
    logic dwellLoad;
    logic dwellClear;
  } ctrlStrb_t;

  // datapath -> control comparison results
  typedef struct packed {
    logic aboveExit;
    logic belowEntry;
    logic aboveAdd;
    logic belowShed;
    logic dwellDone;
    logic sleepOk;
  } cmpFlags_t;

  // PFM entry level in 5 mA units
  function automatic logic [7:0] entryLvl5(input logic [2:0] code);
    case (code)
      3'd0:    return 8'd20;
      3'd1:    return 8'd25;
      3'd2:    return 8'd30;
      3'd3:    return 8'd35;
      default: return 8'd45;
    endcase
  endfunction

  // PFM exit level in 5 mA units
  function automatic logic [7:0] exitLvl5(input logic [2:0] code);
    case (code)
      3'd4:    return 8'd45;
      3'd5:    return 8'd55;
      3'd6:    return 8'd65;
      3'd7:    return 8'd75;
      default: return 8'd35;
    endcase
  endfunction

  // per-phase add level in 10 mA units
  function automatic logic [6:0] addLvl10(input logic [2:0] code);
    logic [2:0] c;
    c = (code < 3'd2) ? 3'd2 : code;
    return 7'((c + 4'd3) * 4'd10);
  endfunction

  // per-phase shed level in 10 mA units
  function automatic logic [6:0] shedLvl10(input logic [2:0] code);
    logic [2:0] c;
    c = (code > 3'd5) ? 3'd5 : code;
    return 7'((c + 4'd3) * 4'd10);
  endfunction

endpackage

// File: rtl/lmc_datapath.sv
module lmc_datapath
  import lmc_pkg::*;
#(
  parameter int NPH     = 6,
  parameter int LOAD_W  = 12,
  parameter int DWELL_W = 8,
  localparam int PH_W   = $clog2(NPH + 1),
  localparam int THR_W  = LOAD_W + 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [PH_W-1:0]    phaseCount,
  input  logic [LOAD_W-1:0]  loadCur,
  input  logic [2:0]         pfmEntryCode,
  input  logic [2:0]         pfmExitCode,
  input  logic [2:0]         phaseAddCode,
  input  logic [2:0]         phaseShedCode,
  input  logic [DWELL_W-1:0] dwellTicks,
  input  logic               lowPwrEnable,
  input  logic               lowPwrAllow,
  input  logic               sleepIn,
  input  logic               sleepPolHigh,
  output cmpFlags_t          flags,
  output logic [NPH-1:0]     phaseEn,
  output logic               cfgErr
);

  logic [7:0]         entry5, exit5;
  logic [6:0]         addLvl, shedLvl;
  logic [THR_W-1:0]   addThr, shedThr, loadExt;
  logic [LOAD_W:0]    load2x;
  logic [DWELL_W-1:0] dwellCnt;

  assign entry5  = entryLvl5(pfmEntryCode);
  assign exit5   = exitLvl5(pfmExitCode);
  assign addLvl  = addLvl10(phaseAddCode);
  assign shedLvl = shedLvl10(phaseShedCode);

  assign addThr  = THR_W'(addLvl) * THR_W'(phaseCount);
  assign shedThr = THR_W'(shedLvl) * THR_W'(phaseCount);
  assign loadExt = THR_W'(loadCur);
  assign load2x  = {loadCur, 1'b0};

  assign flags.aboveExit  = load2x > (LOAD_W+1)'(exit5);
  assign flags.belowEntry = load2x < (LOAD_W+1)'(entry5);
  assign flags.aboveAdd   = loadExt > addThr;
  assign flags.belowShed  = loadExt < shedThr;
  assign flags.dwellDone  = (dwellCnt == '0);
  assign flags.sleepOk    = lowPwrEnable && lowPwrAllow && (sleepIn == sleepPolHigh);

  assign cfgErr = (addLvl <= shedLvl) || ({1'b0, exit5} < ({1'b0, entry5} + 9'd30));

  always_ff @(posedge clk) begin
    if (!rstN || strb.dwellClear) dwellCnt <= '0;
    else if (strb.dwellLoad)      dwellCnt <= dwellTicks;
    else if (dwellCnt != '0)      dwellCnt <= dwellCnt - 1'b1;
  end

  for (genvar i = 0; i < NPH; i++) begin : g_en
    assign phaseEn[i] = (phaseCount > PH_W'(i));
  end

  AST_THERMO_EN: assert property (@(posedge clk) disable iff (!rstN)
    ($countones(phaseEn) == int'(phaseCount)) && phaseEn[0]); // R10

endmodule

// File: rtl/lmc_control.sv
module lmc_control
  import lmc_pkg::*;
#(
  parameter int NPH   = 6,
  localparam int PH_W = $clog2(NPH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            convEnable,
  input  logic            forcePwm,
  input  logic            loadValid,
  input  cmpFlags_t       flags,
  output ctrlStrb_t       strb,
  output logic [PH_W-1:0] phaseCount,
  output logic [1:0]      modeOut
);

  logic [PH_W-1:0] phaseQ, phaseNext;
  logic pwmQ, pwmNext, lpQ, lpNext;

  always_comb begin
    pwmNext   = pwmQ;
    phaseNext = phaseQ;
    strb      = '0;
    if (!convEnable) begin
      pwmNext         = forcePwm;
      phaseNext       = PH_W'(1);
      strb.dwellClear = 1'b1;
    end else begin
      if (forcePwm) pwmNext = 1'b1;
      else if (loadValid) begin
        if (pwmQ && flags.belowEntry)      pwmNext = 1'b0;
        else if (!pwmQ && flags.aboveExit) pwmNext = 1'b1;
      end
      if (!pwmNext) begin
        phaseNext = PH_W'(1);
      end else if (loadValid && flags.dwellDone) begin
        if (flags.aboveAdd && phaseQ < PH_W'(NPH)) begin
          phaseNext      = phaseQ + PH_W'(1);
          strb.dwellLoad = 1'b1;
        end else if (flags.belowShed && phaseQ > PH_W'(1)) begin
          phaseNext      = phaseQ - PH_W'(1);
          strb.dwellLoad = 1'b1;
        end
      end
    end
    lpNext = convEnable && !pwmNext && flags.sleepOk;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseQ <= PH_W'(1);
      pwmQ   <= 1'b0;
      lpQ    <= 1'b0;
    end else begin
      phaseQ <= phaseNext;
      pwmQ   <= pwmNext;
      lpQ    <= lpNext;
    end
  end

  assign phaseCount = phaseQ;
  assign modeOut    = {pwmQ, lpQ};

  AST_PHASE_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    phaseQ >= PH_W'(1) && phaseQ <= PH_W'(NPH)); // R6
  AST_ONE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != $past(phaseQ)) && pwmQ && $past(convEnable) |->
      (phaseQ == $past(phaseQ) + PH_W'(1)) || (phaseQ == $past(phaseQ) - PH_W'(1))); // R8
  AST_NO_EVAL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    $past(convEnable) && !$past(loadValid) |-> $stable(phaseQ)); // R8
  AST_DWELL_GAP: assert property (@(posedge clk) disable iff (!rstN)
    (phaseQ != $past(phaseQ)) && pwmQ && $past(convEnable) |-> $past(flags.dwellDone)); // R9
  AST_FORCED_PWM: assert property (@(posedge clk) disable iff (!rstN)
    convEnable && forcePwm |=> modeOut == MODE_PWM); // R3
  AST_DISABLED_ONE: assert property (@(posedge clk) disable iff (!rstN)
    !convEnable |=> phaseCount == PH_W'(1)); // R2
  AST_LP_NEEDS_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    modeOut == MODE_LPFM |-> $past(flags.sleepOk)); // R12

endmodule

// File: rtl/load_mode_ctl.sv
module load_mode_ctl
  import lmc_pkg::*;
#(
  parameter int NPH     = 6,
  parameter int LOAD_W  = 12,
  parameter int DWELL_W = 8,
  localparam int PH_W   = $clog2(NPH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               convEnable,
  input  logic               forcePwm,
  input  logic               lowPwrEnable,
  input  logic               lowPwrAllow,
  input  logic               sleepIn,
  input  logic               sleepPolHigh,
  input  logic [2:0]         pfmEntryCode,
  input  logic [2:0]         pfmExitCode,
  input  logic [2:0]         phaseAddCode,
  input  logic [2:0]         phaseShedCode,
  input  logic [DWELL_W-1:0] dwellTicks,
  input  logic               loadValid,
  input  logic [LOAD_W-1:0]  loadCur,
  output logic [PH_W-1:0]    phaseCount,
  output logic [1:0]         modeOut,
  output logic [NPH-1:0]     phaseEn,
  output logic               cfgErr
);

  ctrlStrb_t strb;
  cmpFlags_t flags;

  lmc_control #(.NPH(NPH)) u_ctrl (
    .clk(clk), .rstN(rstN), .convEnable(convEnable), .forcePwm(forcePwm),
    .loadValid(loadValid), .flags(flags), .strb(strb),
    .phaseCount(phaseCount), .modeOut(modeOut)
  );

  lmc_datapath #(.NPH(NPH), .LOAD_W(LOAD_W), .DWELL_W(DWELL_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .phaseCount(phaseCount),
    .loadCur(loadCur), .pfmEntryCode(pfmEntryCode), .pfmExitCode(pfmExitCode),
    .phaseAddCode(phaseAddCode), .phaseShedCode(phaseShedCode),
    .dwellTicks(dwellTicks), .lowPwrEnable(lowPwrEnable), .lowPwrAllow(lowPwrAllow),
    .sleepIn(sleepIn), .sleepPolHigh(sleepPolHigh), .flags(flags),
    .phaseEn(phaseEn), .cfgErr(cfgErr)
  );

endmodule

// File: tb/load_mode_ctl_tb.sv
module load_mode_ctl_tb;

  logic clk = 1'b0;
  logic rstN, convEnable, forcePwm, lowPwrEnable, lowPwrAllow, sleepIn, sleepPolHigh;
  logic [2:0] pfmEntryCode, pfmExitCode, phaseAddCode, phaseShedCode;
  logic [7:0] dwellTicks;
  logic loadValid;
  logic [11:0] loadCur;
  logic [2:0] phaseCount;
  logic [1:0] modeOut;
  logic [5:0] phaseEn;
  logic cfgErr;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  load_mode_ctl u_dut (
    .clk(clk), .rstN(rstN), .convEnable(convEnable), .forcePwm(forcePwm),
    .lowPwrEnable(lowPwrEnable), .lowPwrAllow(lowPwrAllow), .sleepIn(sleepIn),
    .sleepPolHigh(sleepPolHigh), .pfmEntryCode(pfmEntryCode), .pfmExitCode(pfmExitCode),
    .phaseAddCode(phaseAddCode), .phaseShedCode(phaseShedCode), .dwellTicks(dwellTicks),
    .loadValid(loadValid), .loadCur(loadCur), .phaseCount(phaseCount),
    .modeOut(modeOut), .phaseEn(phaseEn), .cfgErr(cfgErr)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic evalLoad(input int v);
    @(negedge clk);
    loadCur   = 12'(v);
    loadValid = 1'b1;
    @(negedge clk);
    loadValid = 1'b0;
  endtask

  task automatic restart();
    @(negedge clk);
    convEnable = 1'b0;
    @(negedge clk);
    convEnable = 1'b1;
  endtask

  task automatic tReset();
    chk("R1 phase", int'(phaseCount), 1);
    chk("R1 mode", int'(modeOut), 0);
    chk("R1 en", int'(phaseEn), 1);
  endtask

  task automatic tDisabled();
    @(negedge clk); convEnable = 1'b0; forcePwm = 1'b1;
    @(negedge clk);
    chk("R2 forced mode", int'(modeOut), 2);
    chk("R2 phase", int'(phaseCount), 1);
    forcePwm = 1'b0;
    @(negedge clk);
    chk("R2 auto mode", int'(modeOut), 0);
    convEnable = 1'b1;
  endtask

  task automatic tAutoMode();
    restart();
    evalLoad(32); chk("R4 at exit stays PFM", int'(modeOut), 0);
    evalLoad(33); chk("R4 above exit PWM", int'(modeOut), 2);
    evalLoad(18); chk("R5 in band keeps PWM", int'(modeOut), 2);
    evalLoad(17); chk("R5 below entry PFM", int'(modeOut), 0);
  endtask

  task automatic tReservedCodes();
    pfmExitCode = 3'd0;
    evalLoad(18); chk("R4 reserved exit", int'(modeOut), 2);
    pfmEntryCode = 3'd7;
    evalLoad(22); chk("R5 reserved entry", int'(modeOut), 0);
    #1 chk("R13 exit below entry", int'(cfgErr), 1);
    pfmEntryCode = 3'd3; pfmExitCode = 3'd6;
    #1 chk("R13 defaults ok", int'(cfgErr), 0);
    pfmEntryCode = 3'd2; pfmExitCode = 3'd5;
    #1 chk("R13 narrow band", int'(cfgErr), 1);
    pfmEntryCode = 3'd3; pfmExitCode = 3'd6; phaseAddCode = 3'd3; phaseShedCode = 3'd3;
    #1 chk("R13 add equals shed", int'(cfgErr), 1);
    phaseAddCode = 3'd4; phaseShedCode = 3'd2;
  endtask

  task automatic tAdd();
    forcePwm = 1'b1;
    restart();
    evalLoad(70);  chk("R6 at add level", int'(phaseCount), 1);
    evalLoad(71);  chk("R6 add to 2", int'(phaseCount), 2);
    evalLoad(140); chk("R6 scaled level", int'(phaseCount), 2);
    evalLoad(141); chk("R6 add to 3", int'(phaseCount), 3);
    chk("R10 en at 3", int'(phaseEn), 7);
    evalLoad(4095); chk("R8 one step", int'(phaseCount), 4);
    evalLoad(4095); evalLoad(4095);
    chk("R6 reach 6", int'(phaseCount), 6);
    evalLoad(4095); chk("R6 cap at 6", int'(phaseCount), 6);
    chk("R10 en at 6", int'(phaseEn), 63);
    phaseAddCode = 3'd7;
    restart();
    evalLoad(100); chk("R6 code7 hold", int'(phaseCount), 1);
    evalLoad(101); chk("R6 code7 add", int'(phaseCount), 2);
    phaseAddCode = 3'd1;
    restart();
    evalLoad(50); chk("R6 reserved hold", int'(phaseCount), 1);
    evalLoad(51); chk("R6 reserved add", int'(phaseCount), 2);
    phaseAddCode = 3'd4;
  endtask

  task automatic tShed();
    evalLoad(4095); evalLoad(4095); evalLoad(4095); evalLoad(4095);
    chk("R7 start at 6", int'(phaseCount), 6);
    phaseAddCode = 3'd7;
    evalLoad(300); chk("R7 at shed level", int'(phaseCount), 6);
    evalLoad(299); chk("R7 shed to 5", int'(phaseCount), 5);
    phaseShedCode = 3'd7;
    evalLoad(399); chk("R7 reserved shed", int'(phaseCount), 4);
    evalLoad(400); chk("R7 hold at 4", int'(phaseCount), 4);
    phaseAddCode = 3'd4; phaseShedCode = 3'd2;
  endtask

  task automatic tDwell();
    forcePwm = 1'b1; dwellTicks = 8'd5;
    restart();
    @(negedge clk);
    loadCur = 12'd4095; loadValid = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 no eval no change", int'(phaseCount), 1);
    loadValid = 1'b1;
    for (int k = 1; k <= 7; k++) begin
      @(negedge clk);
      if (k == 1) chk("R9 first step", int'(phaseCount), 2);
      if (k == 6) chk("R9 held in dwell", int'(phaseCount), 2);
      if (k == 7) chk("R9 step after dwell", int'(phaseCount), 3);
    end
    loadValid = 1'b0; dwellTicks = 8'd0;
  endtask

  task automatic tPfmDrop();
    forcePwm = 1'b1;
    restart();
    evalLoad(4095); evalLoad(4095);
    chk("R11 pre", int'(phaseCount), 3);
    forcePwm = 1'b0;
    evalLoad(5);
    chk("R11 mode PFM", int'(modeOut), 0);
    chk("R11 back to 1", int'(phaseCount), 1);
  endtask

  task automatic tLowPower();
    lowPwrEnable = 1'b1; lowPwrAllow = 1'b1; sleepPolHigh = 1'b1; sleepIn = 1'b1;
    @(negedge clk); chk("R12 active high", int'(modeOut), 1);
    sleepIn = 1'b0;
    @(negedge clk); chk("R12 sleep off", int'(modeOut), 0);
    sleepPolHigh = 1'b0;
    @(negedge clk); chk("R12 active low", int'(modeOut), 1);
    lowPwrAllow = 1'b0;
    @(negedge clk); chk("R12 not allowed", int'(modeOut), 0);
    lowPwrAllow = 1'b1;
    @(negedge clk); chk("R12 allowed again", int'(modeOut), 1);
    forcePwm = 1'b1;
    @(negedge clk); chk("R3 force over sleep", int'(modeOut), 2);
    evalLoad(0); chk("R3 force at zero load", int'(modeOut), 2);
    forcePwm = 1'b0; lowPwrEnable = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; convEnable = 1'b1; forcePwm = 1'b0;
    lowPwrEnable = 1'b0; lowPwrAllow = 1'b0; sleepIn = 1'b0; sleepPolHigh = 1'b1;
    pfmEntryCode = 3'd3; pfmExitCode = 3'd6; phaseAddCode = 3'd4; phaseShedCode = 3'd2;
    dwellTicks = 8'd0; loadValid = 1'b0; loadCur = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tDisabled();
    tAutoMode();
    tReservedCodes();
    tAdd();
    tShed();
    tDwell();
    tPfmDrop();
    tLowPower();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule